// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Flags

A single-clock FIFO controller with a parameterized word width and storage depth (36 bits by 1,024 words by default). Its behaviour on the read side is fixed by a mode captured during master reset. In standard mode a word reaches the data output only when it is requested with read enable. In fall-through mode the oldest word is moved into the output register without being asked for, and read enable consumes it. That output register adds one word of capacity.

Two flag pins change meaning with the mode. One reports empty in standard mode and "output word valid" in fall-through mode. The other reports full in standard mode and "room for a write" in fall-through mode. Three further flags report half-full, almost-empty and almost-full, and each shifts its threshold by one in fall-through mode. The almost thresholds come from one offset value. A two-bit select picks that value from four parameters during master reset. A synchronous partial reset empties the FIFO and keeps the mode and the offset.

Top module: `dmf_fifo`

## Requirements
- R1: In standard mode, an accepted read (ren high, FIFO not empty) places the oldest word on dout after that clock edge, and dout holds its value at every other edge. dout is 0 after either reset.
- R2: In fall-through mode, a word written into an empty FIFO appears on dout, with ef_or high, one edge after the edge that wrote it and without any read. While ef_or is high and ren is low, dout and ef_or hold.
- R3: The capacity is DEPTH words in standard mode and DEPTH+1 words in fall-through mode. In standard mode ff_ir rises after the DEPTH-th write with no reads. In fall-through mode ff_ir falls after the (DEPTH+1)-th write with no reads.
- R4: A write while the FIFO is at capacity is dropped, and the stored data is unchanged. A read while nothing is readable changes neither the pointers nor dout.
- R5: In standard mode, ef_or=1 means empty and ff_ir=1 means full. In fall-through mode, ef_or=1 means a valid word is on dout and ff_ir=1 means a write would be accepted.
- R6: With c the number of words held, counting the output register in fall-through mode, hf is 1 when c >= DEPTH/2+1 in standard mode and when c >= DEPTH/2+2 in fall-through mode.
- R7: pae is 1 when c <= n in standard mode and when c <= n+1 in fall-through mode, where n is the selected offset.
- R8: paf is 1 when c >= DEPTH-n in standard mode and when c >= DEPTH+1-n in fall-through mode.
- R9: The offset n is OFFSET_0, OFFSET_1, OFFSET_2 or OFFSET_3 for ofs_sel = 0, 1, 2 or 3. It is captured during master reset, and the same value serves as the empty and full offset.
- R10: prst high at a clock edge empties the FIFO, clears dout and both pointers, and ignores wen and ren at that edge. It keeps the mode and the offset.
- R11: fwft_sel (1 = fall-through) and ofs_sel are sampled at every edge while mrst_n is low and at the first edge after its release. Accesses at that first edge are ignored. Later changes of fwft_sel or ofs_sel have no effect.
- R12: All flags are registered. They reflect an access from the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, asynchronous assert, active low |
| prst | input | 1 | Partial reset, synchronous, active high |
| fwft_sel | input | 1 | Mode select: 1 = fall-through, 0 = standard |
| ofs_sel | input | 2 | Default offset select |
| wen | input | 1 | Write enable |
| din | input | W | Write data |
| ren | input | 1 | Read enable |
| dout | output | W | Read data register |
| ef_or | output | 1 | Empty (standard) / output valid (fall-through) |
| ff_ir | output | 1 | Full (standard) / input room (fall-through) |
| hf | output | 1 | Half-full |
| pae | output | 1 | Programmable almost-empty |
| paf | output | 1 | Programmable almost-full |

## Verification
The bench drives the FIFO to exactly DEPTH and DEPTH+1 words, then keeps writing. A design that allows one word too many, or one too few, would either overwrite the oldest word or drop ff_ir one write early, and the data draining afterwards would not match. The bench checks the one-edge fall-through latency into an empty FIFO. A missing or extra stage would show a stale dout, or ef_or at the wrong edge. It walks the almost-empty threshold one word at a time under each offset select, so an off-by-one or an unapplied fall-through shift shows at the boundary word. It also toggles the mode pin during operation and applies partial reset mid-stream, which catches a design that re-samples the mode or loses the offset.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

  // Raw occupancy conditions; pin meanings are applied at the top level.
  typedef struct packed {
    logic empty;
    logic full;
    logic half;
    logic aempty;
    logic afull;
  } flag_s;

endpackage

// File: rtl/dmf_store.sv
module dmf_store #(
  parameter int W     = 36,
  parameter int DEPTH = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW-1:0] wptr_inc, rptr_inc;
  logic [AW-1:0] wptr_d, rptr_d;
  logic [W-1:0]  rdata_q, rdata_d;

  // Pointer advance: natural wrap for a power-of-two depth, explicit compare otherwise.
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wptr_inc = wptr_q + AW'(1);
      assign rptr_inc = rptr_q + AW'(1);
    end else begin : g_wrap
      assign wptr_inc = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
      assign rptr_inc = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
    end
  endgenerate

  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    rdata_d = rdata_q;
    if (clr) begin
      wptr_d  = '0;
      rptr_d  = '0;
      rdata_d = '0;
    end else begin
      if (wr)  wptr_d = wptr_inc;
      if (pop) begin
        rptr_d  = rptr_inc;
        rdata_d = mem[rptr_q];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      rdata_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      rdata_q <= rdata_d;
    end
  end

  // Storage array: no reset, written only under its enable.
  always_ff @(posedge clk) begin
    if (wr) mem[wptr_q] <= wdata;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/dmf_occ.sv
module dmf_occ #(
  parameter int DEPTH = 1024,
  parameter int CW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fwft,
  input  logic          wen,
  input  logic          ren,
  output logic          wr_ok,
  output logic          ram_pop,
  output logic          out_valid,
  output logic [CW-1:0] occ_nxt
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] ram_cnt_q, ram_cnt_d;
  logic [CW-1:0] occ_q;
  logic          ov_q, ov_d;
  logic [CW-1:0] cap;
  logic          ram_has;
  logic          out_pop;

  always_comb begin
    cap     = fwft ? DEPTH_C + CW'(1) : DEPTH_C;
    ram_has = (ram_cnt_q != '0);
    wr_ok   = wen && !clr && (occ_q != cap);
    if (fwft) begin
      // The output register is consumed by ren and refilled whenever it is free.
      out_pop = ren && ov_q && !clr;
      ram_pop = !clr && ram_has && (!ov_q || out_pop);
      ov_d    = !clr && (ram_pop || (ov_q && !out_pop));
    end else begin
      out_pop = 1'b0;
      ram_pop = ren && ram_has && !clr;
      ov_d    = 1'b0;
    end
    if (clr) ram_cnt_d = '0;
    else     ram_cnt_d = ram_cnt_q + CW'(wr_ok) - CW'(ram_pop);
    occ_nxt = ram_cnt_d + CW'(ov_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_cnt_q <= '0;
      occ_q     <= '0;
      ov_q      <= 1'b0;
    end else begin
      ram_cnt_q <= ram_cnt_d;
      occ_q     <= occ_nxt;
      ov_q      <= ov_d;
    end
  end

  assign out_valid = ov_q;

endmodule

// File: rtl/dmf_flags.sv
module dmf_flags
  import dmf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic [CW-1:0] occ_nxt,
  input  logic [CW-1:0] ofs,
  output flag_s         flags
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

  logic [CW-1:0] shift;
  logic [CW-1:0] cap, ae_lim, af_lim, hf_lim;
  flag_s         flags_d, flags_q;

  always_comb begin
    shift  = CW'(fwft);
    cap    = DEPTH_C + shift;
    ae_lim = ofs + shift;
    af_lim = DEPTH_C + shift - ofs;
    hf_lim = HALF_C + shift;
    flags_d.empty  = (occ_nxt == '0);
    flags_d.full   = (occ_nxt == cap);
    flags_d.half   = (occ_nxt >  hf_lim);
    flags_d.aempty = (occ_nxt <= ae_lim);
    flags_d.afull  = (occ_nxt >= af_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '{empty: 1'b1, full: 1'b0, half: 1'b0, aempty: 1'b1, afull: 1'b0};
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;

endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo
  import dmf_pkg::*;
#(
  parameter int W        = 36,
  parameter int DEPTH    = 1024,
  parameter int OFFSET_0 = 7,
  parameter int OFFSET_1 = 63,
  parameter int OFFSET_2 = 127,
  parameter int OFFSET_3 = 255
) (
  input  logic         clk,
  input  logic         mrst_n,
  input  logic         prst,
  input  logic         fwft_sel,
  input  logic [1:0]   ofs_sel,
  input  logic         wen,
  input  logic [W-1:0] din,
  input  logic         ren,
  output logic [W-1:0] dout,
  output logic         ef_or,
  output logic         ff_ir,
  output logic         hf,
  output logic         pae,
  output logic         paf
);

  localparam int CW = $clog2(DEPTH + 2);

  logic          in_cfg_q;
  fifo_mode_e    mode_q;
  logic [CW-1:0] ofs_q, ofs_pick;
  logic          fwft;
  logic          clr;
  logic          wr_ok, ram_pop, out_valid;
  logic [CW-1:0] occ_nxt;
  flag_s         flags;

  // Configuration window: open during master reset and for the first edge after it.
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) in_cfg_q <= 1'b1;
    else         in_cfg_q <= 1'b0;
  end

  always_comb begin
    case (ofs_sel)
      2'd0:    ofs_pick = CW'(OFFSET_0);
      2'd1:    ofs_pick = CW'(OFFSET_1);
      2'd2:    ofs_pick = CW'(OFFSET_2);
      default: ofs_pick = CW'(OFFSET_3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (in_cfg_q) begin
      mode_q <= fifo_mode_e'(fwft_sel);
      ofs_q  <= ofs_pick;
    end
  end

  assign fwft = (mode_q == MODE_FWFT);
  assign clr  = prst || in_cfg_q;

  dmf_occ #(.DEPTH(DEPTH), .CW(CW)) occ_i (
    .clk       (clk),
    .rst_n     (mrst_n),
    .clr       (clr),
    .fwft      (fwft),
    .wen       (wen),
    .ren       (ren),
    .wr_ok     (wr_ok),
    .ram_pop   (ram_pop),
    .out_valid (out_valid),
    .occ_nxt   (occ_nxt)
  );

  dmf_store #(.W(W), .DEPTH(DEPTH)) store_i (
    .clk   (clk),
    .rst_n (mrst_n),
    .clr   (clr),
    .wr    (wr_ok),
    .wdata (din),
    .pop   (ram_pop),
    .rdata (dout)
  );

  dmf_flags #(.DEPTH(DEPTH), .CW(CW)) flags_i (
    .clk     (clk),
    .rst_n   (mrst_n),
    .fwft    (fwft),
    .occ_nxt (occ_nxt),
    .ofs     (ofs_q),
    .flags   (flags)
  );

  assign ef_or = fwft ? out_valid : flags.empty;
  assign ff_ir = fwft ? !flags.full : flags.full;
  assign hf    = flags.half;
  assign pae   = flags.aempty;
  assign paf   = flags.afull;

endmodule

// File: rtl/dmf_fifo_chk.sv
module dmf_fifo_chk #(
  parameter int W = 36
) (
  input logic         clk,
  input logic         mrst_n,
  input logic         cfg_q,
  input logic         prst,
  input logic         fwft,
  input logic         wen,
  input logic         ren,
  input logic [W-1:0] dout,
  input logic         ef_or,
  input logic         ff_ir,
  input logic         hf,
  input logic         pae,
  input logic         paf
);

  // R4: standard mode, full and not read: stays full, output untouched
  a_r4_no_write_when_full: assert property (@(posedge clk) disable iff (!mrst_n || cfg_q)
    (!fwft && ff_ir && !ren && !prst) |=> (ff_ir && $stable(dout)));

  // R4: standard mode, empty and not written: stays empty, output untouched
  a_r4_no_read_when_empty: assert property (@(posedge clk) disable iff (!mrst_n || cfg_q)
    (!fwft && ef_or && !wen && !prst) |=> (ef_or && $stable(dout)));

  // R2: fall-through head word is held until consumed
  a_r2_head_held: assert property (@(posedge clk) disable iff (!mrst_n || cfg_q)
    (fwft && ef_or && !ren && !prst) |=> (ef_or && $stable(dout)));

  // R3: fall-through, no room and no read: still no room
  a_r3_no_room_held: assert property (@(posedge clk) disable iff (!mrst_n || cfg_q)
    (fwft && !ff_ir && !ren && !prst) |=> !ff_ir);

  // R5: flag pair consistency in each mode
  a_r5_flag_pairs: assert property (@(posedge clk) disable iff (!mrst_n || cfg_q)
    fwft ? (ef_or || ff_ir) : !(ef_or && ff_ir));

  // R7: an empty FIFO is also almost empty and not half full
  a_r7_empty_is_almost: assert property (@(posedge clk) disable iff (!mrst_n || cfg_q)
    (!fwft && ef_or) |-> (pae && !hf));

  // R8: a FIFO at capacity is almost full and half full
  a_r8_full_is_almost: assert property (@(posedge clk) disable iff (!mrst_n || cfg_q)
    (fwft ? !ff_ir : ff_ir) |-> (paf && hf));

  // R10: partial reset leaves an empty FIFO
  a_r10_prst_empties: assert property (@(posedge clk) disable iff (!mrst_n || cfg_q)
    prst |=> (!hf && pae && (fwft ? !ef_or : ef_or)));

  // R11: mode does not change outside the configuration window
  a_r11_mode_fixed: assert property (@(posedge clk) disable iff (!mrst_n || cfg_q)
    1'b1 |-> $stable(fwft));

endmodule

bind dmf_fifo dmf_fifo_chk #(.W(W)) chk_i (
  .clk    (clk),
  .mrst_n (mrst_n),
  .cfg_q  (in_cfg_q),
  .prst   (prst),
  .fwft   (fwft),
  .wen    (wen),
  .ren    (ren),
  .dout   (dout),
  .ef_or  (ef_or),
  .ff_ir  (ff_ir),
  .hf     (hf),
  .pae    (pae),
  .paf    (paf)
);

// File: tb/dmf_fifo_tb_top.sv
module dmf_fifo_tb_top;

  localparam int W     = 16;
  localparam int DEPTH = 16;
  localparam int OFS0 = 1, OFS1 = 2, OFS2 = 3, OFS3 = 5;

  logic         clk = 1'b0;
  logic         mrst_n, prst, fwft_sel, wen, ren;
  logic [1:0]   ofs_sel;
  logic [W-1:0] din;
  logic [W-1:0] dout;
  logic         ef_or, ff_ir, hf, pae, paf;

  always #5 clk = ~clk;

  dmf_fifo #(.W(W), .DEPTH(DEPTH), .OFFSET_0(OFS0), .OFFSET_1(OFS1),
             .OFFSET_2(OFS2), .OFFSET_3(OFS3)) dut_i (
    .clk(clk), .mrst_n(mrst_n), .prst(prst), .fwft_sel(fwft_sel), .ofs_sel(ofs_sel),
    .wen(wen), .din(din), .ren(ren), .dout(dout), .ef_or(ef_or), .ff_ir(ff_ir),
    .hf(hf), .pae(pae), .paf(paf));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference model state
  logic [W-1:0] q[$];
  bit           ov_m;
  logic [W-1:0] dout_m;
  bit           mode_m;
  int           n_m;

  function automatic int ofs_of(int s);
    case (s)
      0: return OFS0;
      1: return OFS1;
      2: return OFS2;
      default: return OFS3;
    endcase
  endfunction

  function automatic int count_m();
    return q.size() + int'(ov_m);
  endfunction

  // {ef_or, ff_ir, hf, pae, paf} expected for count c (R5..R8)
  function automatic logic [4:0] exp_flags(int c, bit ov, bit fw, int n);
    int sh = fw ? 1 : 0;
    logic ef, ff;
    ef = fw ? ov : (c == 0);
    ff = fw ? (c < DEPTH + 1) : (c == DEPTH);
    return {ef, ff, c >= DEPTH/2 + 1 + sh, c <= n + sh, c >= DEPTH + sh - n};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R12: outputs sampled just after the edge that performed the access
  task automatic check_all();
    logic [4:0] e = exp_flags(count_m(), ov_m, mode_m, n_m);
    chk(ef_or === e[4], "R5 ef_or", 64'(ef_or), 64'(e[4]));
    chk(ff_ir === e[3], "R5 ff_ir", 64'(ff_ir), 64'(e[3]));
    chk(hf    === e[2], "R6 hf",    64'(hf),    64'(e[2]));
    chk(pae   === e[1], "R7 pae",   64'(pae),   64'(e[1]));
    chk(paf   === e[0], "R8 paf",   64'(paf),   64'(e[0]));
    if (!mode_m)   chk(dout === dout_m, "R1 dout", 64'(dout), 64'(dout_m));
    else if (ov_m) chk(dout === dout_m, "R2 dout", 64'(dout), 64'(dout_m));
  endtask

  task automatic cyc(bit w, bit r, logic [W-1:0] d, bit p = 1'b0, bit tog = 1'b0);
    int  c;
    bit  wr_ok, rd_ok, ld;
    @(negedge clk);
    wen = w; ren = r; din = d; prst = p;
    if (tog) begin fwft_sel = $urandom % 2; ofs_sel = 2'($urandom % 4); end
    c = count_m();
    if (p) begin
      q.delete(); ov_m = 0; dout_m = '0;
    end else if (!mode_m) begin
      wr_ok = w && (c < DEPTH);
      rd_ok = r && (c > 0);
      if (rd_ok) dout_m = q.pop_front();
      if (wr_ok) q.push_back(d);
    end else begin
      wr_ok = w && (c < DEPTH + 1);
      rd_ok = r && ov_m;
      ld    = (q.size() > 0) && (!ov_m || rd_ok);
      if (ld) dout_m = q.pop_front();
      ov_m  = ld ? 1'b1 : (rd_ok ? 1'b0 : ov_m);
      if (wr_ok) q.push_back(d);
    end
    @(posedge clk);
    #3;
    check_all();
  endtask

  task automatic do_reset(bit fw, int sel);
    @(negedge clk);
    mrst_n = 1'b0; prst = 0; wen = 0; ren = 0; din = '0;
    fwft_sel = fw; ofs_sel = 2'(sel);
    repeat (3) @(negedge clk);
    mrst_n = 1'b1;
    q.delete(); ov_m = 0; dout_m = '0; mode_m = fw; n_m = ofs_of(sel);
    @(posedge clk);   // configuration edge
    #3;
    check_all();
    chk(dout === '0, "R1 reset dout", 64'(dout), 64'd0);
  endtask

  // R9: walk the almost-empty boundary one word at a time from empty
  task automatic thr_walk();
    int lim = n_m + (mode_m ? 1 : 0);
    for (int i = 0; i < lim; i++) cyc(1, 0, W'(16'h300 + i));
    chk(pae === 1'b1, "R9 pae at n", 64'(pae), 64'd1);
    cyc(1, 0, W'(16'h3ff));
    chk(pae === 1'b0, "R9 pae past n", 64'(pae), 64'd0);
  endtask

  task automatic rand_run(int cycles, int pw, int pr, bit tog);
    for (int i = 0; i < cycles; i++)
      cyc(($urandom % 100) < pw, ($urandom % 100) < pr, W'($urandom), 1'b0, tog);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    mrst_n = 1'b1; prst = 0; wen = 0; ren = 0; din = '0; fwft_sel = 0; ofs_sel = 0;

    // ---------------- standard mode ----------------
    do_reset(0, 0);
    cyc(0, 1, '0);                                   // R4: read while empty
    chk(dout === '0, "R4 empty read", 64'(dout), 64'd0);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, 0, W'(16'h100 + i));
      if (i == DEPTH - 2) chk(ff_ir === 1'b0, "R3 not full yet", 64'(ff_ir), 64'd0);
    end
    chk(ff_ir === 1'b1, "R3 full after DEPTH", 64'(ff_ir), 64'd1);
    cyc(1, 0, W'(16'hdead));                         // R4: writes while full
    cyc(1, 0, W'(16'hbeef));
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, '0);   // R1: drain in order
    chk(dout === W'(16'h100 + DEPTH - 1), "R4 last word", 64'(dout), 64'(16'h100 + DEPTH - 1));
    chk(ef_or === 1'b1, "R4 no extra word", 64'(ef_or), 64'd1);
    thr_walk();
    rand_run(300, 60, 40, 1'b1);                     // R11: mode pin toggles
    rand_run(200, 40, 60, 1'b1);
    for (int i = 0; i < 5; i++) cyc(1, 0, W'(i));
    cyc(1, 1, '0, 1'b1);                             // R10
    chk(ef_or === 1'b1, "R10 empty after prst", 64'(ef_or), 64'd1);
    chk(dout === '0, "R10 dout cleared", 64'(dout), 64'd0);
    thr_walk();                                      // R10: offset kept

    // ---------------- fall-through mode ----------------
    do_reset(1, 2);
    chk(ef_or === 1'b0, "R5 no output word", 64'(ef_or), 64'd0);
    cyc(1, 0, W'(16'h0abc));
    chk(ef_or === 1'b0, "R2 not yet visible", 64'(ef_or), 64'd0);
    cyc(0, 0, '0);
    chk(ef_or === 1'b1, "R2 falls through", 64'(ef_or), 64'd1);
    chk(dout === W'(16'h0abc), "R2 head word", 64'(dout), 64'h0abc);
    for (int i = 1; i < DEPTH + 1; i++) begin
      cyc(1, 0, W'(16'h200 + i));
      if (i == DEPTH - 1) chk(ff_ir === 1'b1, "R3 room at DEPTH", 64'(ff_ir), 64'd1);
    end
    chk(ff_ir === 1'b0, "R3 no room at DEPTH+1", 64'(ff_ir), 64'd0);
    cyc(1, 0, W'(16'hdead));                         // R4: dropped
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 1, '0);
    chk(ef_or === 1'b0, "R4 nothing left", 64'(ef_or), 64'd0);
    thr_walk();
    rand_run(300, 55, 45, 1'b1);
    cyc(0, 0, '0, 1'b1);                             // R10
    chk(ef_or === 1'b0, "R10 fwft empty", 64'(ef_or), 64'd0);
    rand_run(200, 70, 30, 1'b1);

    do_reset(1, 3);
    thr_walk();
    rand_run(250, 50, 50, 1'b0);
    do_reset(0, 1);
    thr_walk();
    rand_run(250, 50, 50, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule